// File: doc/BRIEF.md
# Predicate-Qualified VLIW Dispatch Stage

This block sits between decode and register read in a wide-issue pipeline. Each cycle it takes a fetch packet of several operations. The packet may hold more operations than there are functional units. Every operation names a unit class (integer ALU or memory), a slot within that class, and a guard predicate. The stage reads the predicate state during dispatch. It drops every operation whose guard is false and passes the rest to their unit slots through a register.

The compiler may put several operations on one unit slot, provided their guards are mutually exclusive. Only the one whose guard holds reaches the unit. Slots in fetch, decode and dispatch are always used, but a functional unit is only used when some operation aimed at it is enabled.

A small predicate file lives inside the stage. It is written by compare results: one compare sets a destination predicate to the condition and a second destination to its inverse. The compare is itself guarded. Its result reaches dispatch reads after a latency of 1 to 3 cycles, which is a parameter.

Top module: `pq_dispatch`

## Requirements
- R1: After synchronous reset, no slot issues, `conflict_err` is low, and every predicate other than index 0 reads false.
- R2: Predicate index 0 always reads true. A compare that names index 0 as a destination leaves it true.
- R3: Operation i of the packet sits in `pkt` bits [i*17 +: 17]. Its fields are: bit 16 valid; bit 15 class (0 ALU, 1 MEM); bits 14:13 slot; bits 12:8 predicate index; bits 7:0 payload. A valid operation with a true guard is issued on its class/slot one cycle after the packet is presented, with its payload.
- R4: A slot with no valid, enabled operation aimed at it has its valid output low and its payload output zero in that cycle.
- R5: Suppose two or more enabled operations target the same slot. The slot issues the one with the lowest fetch index and `conflict_err` rises in the same cycle as that issue.
- R6: `conflict_err` stays high until reset.
- R7: Suppose a compare is presented in cycle k with a true guard. Then predicate `cmp_dst_t` takes `cmp_cond` and `cmp_dst_f` takes its inverse. Both are seen by packets presented in cycle k+CMP_LAT and later, and by no earlier packet. The compare's guard is read in cycle k, with any result already visible in that cycle.
- R8: A compare whose guard reads false in its cycle changes no predicate.
- R9: An operation whose slot index is not below the unit count of its class is dropped.
- R10: Operations sharing a slot with complementary guards issue the one whose guard holds and raise no conflict.
- R11: When both destinations of one compare are the same index, that predicate takes `cmp_cond`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt | input | FETCH_W*17 | Fetch packet of decoded operations |
| cmp_vld | input | 1 | Compare result present |
| cmp_guard | input | 5 | Guard predicate index of the compare |
| cmp_dst_t | input | 5 | Destination receiving the condition |
| cmp_dst_f | input | 5 | Destination receiving the inverted condition |
| cmp_cond | input | 1 | Compare outcome |
| alu_vld | output | N_ALU | Per ALU slot issue valid |
| alu_pay | output | N_ALU*8 | Per ALU slot issued payload |
| mem_vld | output | N_MEM | Per memory slot issue valid |
| mem_pay | output | N_MEM*8 | Per memory slot issued payload |
| conflict_err | output | 1 | Sticky flag: two enabled operations met on one slot |

## Verification
The assertions expect nothing of the packet contents. They do not rely on the compiler's disjointness promise, so they must hold even when enabled operations collide on a slot. They rely only on reset being applied before use. The stimulus starts with directed sequences in which shared slots carry complementary guards produced by earlier compares. It then breaks disjointness on purpose to raise the error flag. A constrained-random phase follows, drawing guard and destination indices from a small range so that collisions, drops and compare bypass happen often.

// File: rtl/pqd_pkg.sv
package pqd_pkg;
    localparam int PIDX_W = 5;
    localparam int NPRED  = 1 << PIDX_W;
    localparam int SLOT_W = 2;
    localparam int PAY_W  = 8;
    localparam int OP_W   = 2 + SLOT_W + PIDX_W + PAY_W;

    typedef enum logic {
        UC_ALU = 1'b0,
        UC_MEM = 1'b1
    } ucls_e;

    typedef struct packed {
        logic              vld;
        ucls_e             cls;
        logic [SLOT_W-1:0] slot;
        logic [PIDX_W-1:0] pidx;
        logic [PAY_W-1:0]  pay;
    } fop_t;

    typedef struct packed {
        logic              en;
        logic [PIDX_W-1:0] dst_t;
        logic [PIDX_W-1:0] dst_f;
        logic              cond;
    } pwr_t;

    // Index 0 is the constant-true guard.
    function automatic logic pred_rd(input logic [NPRED-1:0] v,
                                     input logic [PIDX_W-1:0] i);
        return (i == '0) ? 1'b1 : v[i];
    endfunction
endpackage

// File: rtl/pqd_pred_file.sv
module pqd_pred_file
    import pqd_pkg::*;
#(
    parameter int CMP_LAT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmp_vld,
    input  logic [PIDX_W-1:0] cmp_guard,
    input  logic [PIDX_W-1:0] cmp_dst_t,
    input  logic [PIDX_W-1:0] cmp_dst_f,
    input  logic              cmp_cond,
    output logic [NPRED-1:0]  pview
);
    logic [NPRED-1:0] pregs;
    pwr_t             stg [CMP_LAT];
    pwr_t             wr_now;
    pwr_t             wr_new;

    assign wr_now = stg[CMP_LAT-1];

    // Current view: stored state overlaid with the result retiring this cycle.
    always_comb begin
        pview = pregs;
        if (wr_now.en) begin
            if (wr_now.dst_f != '0) pview[wr_now.dst_f] = ~wr_now.cond;
            if (wr_now.dst_t != '0) pview[wr_now.dst_t] = wr_now.cond;
        end
        pview[0] = 1'b1;
    end

    always_comb begin
        wr_new.en    = cmp_vld & pred_rd(pview, cmp_guard);
        wr_new.dst_t = cmp_dst_t;
        wr_new.dst_f = cmp_dst_f;
        wr_new.cond  = cmp_cond;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pregs <= '0;
            for (int g = 0; g < CMP_LAT; g++) stg[g] <= '0;
        end else begin
            pregs <= pview;
            for (int g = CMP_LAT - 1; g > 0; g--) stg[g] <= stg[g-1];
            stg[0] <= wr_new;
        end
    end
endmodule

// File: rtl/pqd_slot_pick.sv
module pqd_slot_pick
    import pqd_pkg::*;
#(
    parameter int    FETCH_W = 4,
    parameter ucls_e CLS     = UC_ALU,
    parameter int    SLOT    = 0
) (
    input  fop_t             ops [FETCH_W],
    input  logic [NPRED-1:0] pview,
    output logic             hit,
    output logic             multi,
    output logic [PAY_W-1:0] pay
);
    always_comb begin
        hit   = 1'b0;
        multi = 1'b0;
        pay   = '0;
        for (int i = 0; i < FETCH_W; i++) begin
            if (ops[i].vld && ops[i].cls == CLS &&
                ops[i].slot == SLOT_W'(SLOT) && pred_rd(pview, ops[i].pidx)) begin
                if (hit) begin
                    multi = 1'b1;
                end else begin
                    hit = 1'b1;
                    pay = ops[i].pay;
                end
            end
        end
    end
endmodule

// File: rtl/pq_dispatch.sv
module pq_dispatch
    import pqd_pkg::*;
#(
    parameter int FETCH_W = 4,
    parameter int N_ALU   = 2,
    parameter int N_MEM   = 1,
    parameter int CMP_LAT = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [FETCH_W*OP_W-1:0]  pkt,
    input  logic                     cmp_vld,
    input  logic [PIDX_W-1:0]        cmp_guard,
    input  logic [PIDX_W-1:0]        cmp_dst_t,
    input  logic [PIDX_W-1:0]        cmp_dst_f,
    input  logic                     cmp_cond,
    output logic [N_ALU-1:0]         alu_vld,
    output logic [N_ALU*PAY_W-1:0]   alu_pay,
    output logic [N_MEM-1:0]         mem_vld,
    output logic [N_MEM*PAY_W-1:0]   mem_pay,
    output logic                     conflict_err
);
    fop_t                  ops [FETCH_W];
    logic [NPRED-1:0]      pview;
    logic [N_ALU-1:0]      alu_hit, alu_multi;
    logic [N_ALU*PAY_W-1:0] alu_sel;
    logic [N_MEM-1:0]      mem_hit, mem_multi;
    logic [N_MEM*PAY_W-1:0] mem_sel;
    logic                  any_multi;

    for (genvar i = 0; i < FETCH_W; i++) begin : g_unpack
        assign ops[i] = fop_t'(pkt[i*OP_W +: OP_W]);
    end

    pqd_pred_file #(.CMP_LAT(CMP_LAT)) u_pfile (
        .clk       (clk),
        .rst       (rst),
        .cmp_vld   (cmp_vld),
        .cmp_guard (cmp_guard),
        .cmp_dst_t (cmp_dst_t),
        .cmp_dst_f (cmp_dst_f),
        .cmp_cond  (cmp_cond),
        .pview     (pview)
    );

    for (genvar s = 0; s < N_ALU; s++) begin : g_alu
        pqd_slot_pick #(.FETCH_W(FETCH_W), .CLS(UC_ALU), .SLOT(s)) u_pick (
            .ops   (ops),
            .pview (pview),
            .hit   (alu_hit[s]),
            .multi (alu_multi[s]),
            .pay   (alu_sel[s*PAY_W +: PAY_W])
        );
    end

    for (genvar s = 0; s < N_MEM; s++) begin : g_mem
        pqd_slot_pick #(.FETCH_W(FETCH_W), .CLS(UC_MEM), .SLOT(s)) u_pick (
            .ops   (ops),
            .pview (pview),
            .hit   (mem_hit[s]),
            .multi (mem_multi[s]),
            .pay   (mem_sel[s*PAY_W +: PAY_W])
        );
    end

    assign any_multi = (|alu_multi) | (|mem_multi);

    always_ff @(posedge clk) begin
        if (rst) begin
            alu_vld      <= '0;
            alu_pay      <= '0;
            mem_vld      <= '0;
            mem_pay      <= '0;
            conflict_err <= 1'b0;
        end else begin
            alu_vld      <= alu_hit;
            alu_pay      <= alu_sel;
            mem_vld      <= mem_hit;
            mem_pay      <= mem_sel;
            conflict_err <= conflict_err | any_multi;
        end
    end
endmodule

// File: rtl/pqd_checker.sv
module pqd_checker
    import pqd_pkg::*;
#(
    parameter int FETCH_W = 4,
    parameter int N_ALU   = 2,
    parameter int N_MEM   = 1
) (
    input logic                    clk,
    input logic                    rst,
    input logic [FETCH_W*OP_W-1:0] pkt,
    input logic [N_ALU-1:0]        alu_vld,
    input logic [N_ALU*PAY_W-1:0]  alu_pay,
    input logic [N_MEM-1:0]        mem_vld,
    input logic                    conflict_err
);
    logic [FETCH_W-1:0] vbits;
    for (genvar i = 0; i < FETCH_W; i++) begin : g_v
        assign vbits[i] = pkt[i*OP_W + OP_W - 1];
    end

    logic [OP_W-1:0] op0;
    logic            op0_p0_alu0;
    assign op0 = pkt[OP_W-1:0];
    assign op0_p0_alu0 = op0[OP_W-1] && !op0[OP_W-2] &&
                         (op0[OP_W-3 -: SLOT_W] == '0) &&
                         (op0[PAY_W +: PIDX_W] == '0);

    // R6
    a_r6_conflict_sticky: assert property (@(posedge clk) disable iff (rst)
        conflict_err |=> conflict_err);

    // R4
    a_r4_empty_packet_idle: assert property (@(posedge clk) disable iff (rst)
        (vbits == '0) |=> (alu_vld == '0 && mem_vld == '0));

    // R2 / R3
    a_r2_p0_op_issues: assert property (@(posedge clk) disable iff (rst)
        op0_p0_alu0 |=> (alu_vld[0] && alu_pay[PAY_W-1:0] == $past(op0[PAY_W-1:0])));

    // R5
    a_r5_conflict_needs_pair: assert property (@(posedge clk) disable iff (rst)
        $rose(conflict_err) |-> ($countones($past(vbits)) >= 2));
endmodule

bind pq_dispatch pqd_checker #(.FETCH_W(FETCH_W), .N_ALU(N_ALU), .N_MEM(N_MEM)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pkt          (pkt),
    .alu_vld      (alu_vld),
    .alu_pay      (alu_pay),
    .mem_vld      (mem_vld),
    .conflict_err (conflict_err)
);

// File: tb/pq_dispatch_bench.sv
module pq_dispatch_bench;
    localparam int CLK_PER = 10;
    localparam int FW   = 4;
    localparam int NA   = 2;
    localparam int NM   = 1;
    localparam int LAT  = 2;
    localparam int OPW  = 17;
    localparam int PW   = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [FW*OPW-1:0] pkt = '0;
    logic             cmp_vld = 1'b0;
    logic [4:0]       cmp_guard = '0, cmp_dst_t = '0, cmp_dst_f = '0;
    logic             cmp_cond = 1'b0;
    logic [NA-1:0]    alu_vld;
    logic [NA*PW-1:0] alu_pay;
    logic [NM-1:0]    mem_vld;
    logic [NM*PW-1:0] mem_pay;
    logic             conflict_err;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // bench model state
    logic [31:0] m_pred;
    bit          pe [LAT];
    logic [4:0]  pt [LAT];
    logic [4:0]  pf [LAT];
    bit          pc [LAT];
    bit          m_conf;

    always #(CLK_PER/2) clk = ~clk;

    pq_dispatch #(.FETCH_W(FW), .N_ALU(NA), .N_MEM(NM), .CMP_LAT(LAT)) u_pq_dispatch (
        .clk(clk), .rst(rst), .pkt(pkt), .cmp_vld(cmp_vld), .cmp_guard(cmp_guard),
        .cmp_dst_t(cmp_dst_t), .cmp_dst_f(cmp_dst_f), .cmp_cond(cmp_cond),
        .alu_vld(alu_vld), .alu_pay(alu_pay), .mem_vld(mem_vld), .mem_pay(mem_pay),
        .conflict_err(conflict_err)
    );

    function automatic logic [OPW-1:0] mkop(bit v, bit c, int s, int p, int pay);
        return {v, c, 2'(s), 5'(p), 8'(pay)};
    endfunction

    function automatic logic [31:0] model_view();
        logic [31:0] v = m_pred;
        if (pe[LAT-1]) begin
            if (pf[LAT-1] != 0) v[pf[LAT-1]] = ~pc[LAT-1];
            if (pt[LAT-1] != 0) v[pt[LAT-1]] = pc[LAT-1];
        end
        v[0] = 1'b1;
        return v;
    endfunction

    function automatic void model_reset();
        m_pred = '0; m_conf = 0;
        for (int g = 0; g < LAT; g++) begin pe[g] = 0; pt[g] = 0; pf[g] = 0; pc[g] = 0; end
    endfunction

    // one clock: drive packet/compare, predict, advance model, check after edge
    task automatic step(input logic [FW*OPW-1:0] p, input bit cv, input int cg,
                        input int ct, input int cf, input bit cc, input string tag);
        logic [31:0] v;
        logic [NA-1:0] ea_v; logic [NA*PW-1:0] ea_p;
        logic [NM-1:0] em_v; logic [NM*PW-1:0] em_p;
        bit hit, en;
        pkt = p; cmp_vld = cv; cmp_guard = 5'(cg); cmp_dst_t = 5'(ct);
        cmp_dst_f = 5'(cf); cmp_cond = cc;
        v = model_view();
        ea_v = '0; ea_p = '0; em_v = '0; em_p = '0;
        for (int cls = 0; cls < 2; cls++) begin
            for (int s = 0; s < ((cls == 0) ? NA : NM); s++) begin
                hit = 0;
                for (int i = 0; i < FW; i++) begin
                    logic [OPW-1:0] o = p[i*OPW +: OPW];
                    if (o[16] && o[15] == cls[0] && o[14:13] == 2'(s) &&
                        (o[12:8] == 0 || v[o[12:8]])) begin
                        if (hit) m_conf = 1;
                        else begin
                            hit = 1;
                            if (cls == 0) begin ea_v[s] = 1; ea_p[s*PW +: PW] = o[7:0]; end
                            else begin em_v[s] = 1; em_p[s*PW +: PW] = o[7:0]; end
                        end
                    end
                end
            end
        end
        en = cv && (cg == 0 || v[cg]);
        m_pred = v;
        for (int g = LAT - 1; g > 0; g--) begin
            pe[g] = pe[g-1]; pt[g] = pt[g-1]; pf[g] = pf[g-1]; pc[g] = pc[g-1];
        end
        pe[0] = en; pt[0] = 5'(ct); pf[0] = 5'(cf); pc[0] = cc;
        @(negedge clk);
        n_chk++;
        if (alu_vld !== ea_v || alu_pay !== ea_p || mem_vld !== em_v ||
            mem_pay !== em_p || conflict_err !== m_conf) begin
            n_bad++;
            $display("FAIL %s: alu %b/%h mem %b/%h err %b, expected alu %b/%h mem %b/%h err %b",
                     tag, alu_vld, alu_pay, mem_vld, mem_pay, conflict_err,
                     ea_v, ea_p, em_v, em_p, m_conf);
        end
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) step('0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic do_reset();
        rst = 1'b1; pkt = '0; cmp_vld = 0;
        repeat (3) @(negedge clk);
        model_reset();
        rst = 1'b0;
        n_chk++;
        if (alu_vld !== '0 || mem_vld !== '0 || conflict_err !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: alu %b mem %b err %b, expected 0 0 0", alu_vld, mem_vld, conflict_err);
        end
    endtask

    function automatic logic [FW*OPW-1:0] pk4(logic [OPW-1:0] a, logic [OPW-1:0] b,
                                               logic [OPW-1:0] c, logic [OPW-1:0] d);
        return {d, c, b, a};
    endfunction

    initial begin
        void'($urandom(32'h5eed_0042));
        @(negedge clk);
        do_reset();
        // R1: fresh predicates are false, p0 true
        step(pk4(mkop(1,0,0,3,8'h11), mkop(1,0,1,0,8'h22), mkop(1,1,0,9,8'h33), '0), 0,0,0,0,0, "R1 preds false");
        // R3: every slot fed on p0
        step(pk4(mkop(1,0,0,0,8'hA1), mkop(1,0,1,0,8'hA2), mkop(1,1,0,0,8'hA3), '0), 0,0,0,0,0, "R3 all slots");
        // R4: nothing enabled
        step(pk4(mkop(0,0,0,0,8'h55), mkop(1,0,1,7,8'h66), '0, '0), 0,0,0,0,0, "R4 idle");
        // R7: compare p4=1 p5=0, watch reads at k, k+1, k+2
        step(pk4(mkop(1,0,0,4,8'hB0), mkop(1,0,1,5,8'hB1), '0, '0), 1,0,4,5,1, "R7 cycle k");
        step(pk4(mkop(1,0,0,4,8'hB2), mkop(1,0,1,5,8'hB3), '0, '0), 0,0,0,0,0, "R7 before latency");
        step(pk4(mkop(1,0,0,4,8'hB4), mkop(1,0,1,5,8'hB5), '0, '0), 0,0,0,0,0, "R7 after latency");
        // R10: complementary guards share ALU0
        step(pk4(mkop(1,0,0,5,8'hC0), mkop(1,1,0,9,8'hC9), mkop(1,0,0,4,8'hC1), '0), 0,0,0,0,0, "R10 disjoint share");
        // R8: guard p5 false, compare would flip p4/p5
        step('0, 1,5,5,4,1, "R8 false guard");
        idle(LAT, "R8 wait");
        step(pk4(mkop(1,0,0,4,8'hD0), mkop(1,0,1,5,8'hD1), '0, '0), 0,0,0,0,0, "R8 unchanged");
        // R11: same destination both ways
        step('0, 1,0,6,6,0, "R11 cond0");
        idle(LAT, "R11 wait");
        step(pk4(mkop(1,0,0,6,8'hE0), '0, '0, '0), 1,0,6,6,1, "R11 p6 false");
        idle(LAT - 1, "R11 wait");
        step(pk4(mkop(1,0,0,6,8'hE1), '0, '0, '0), 0,0,0,0,0, "R11 p6 true");
        // R2: write attempt to p0
        step('0, 1,0,7,0,0, "R2 write p0");
        idle(LAT, "R2 wait");
        step(pk4(mkop(1,1,0,0,8'hF0), '0, '0, '0), 0,0,0,0,0, "R2 p0 true");
        // R9: out-of-range slots dropped
        step(pk4(mkop(1,1,1,0,8'h91), mkop(1,0,2,0,8'h92), mkop(1,0,3,0,8'h93), '0), 0,0,0,0,0, "R9 drop");
        // R5: collision on ALU1, lowest index wins
        step(pk4('0, mkop(1,0,1,0,8'h51), mkop(1,0,1,4,8'h52), mkop(1,0,1,0,8'h53)), 0,0,0,0,0, "R5 collision");
        // R6: flag holds, then reset clears
        idle(5, "R6 sticky");
        do_reset();
        // random phase
        for (int n = 0; n < 400; n++) begin
            logic [FW*OPW-1:0] p;
            for (int i = 0; i < FW; i++)
                p[i*OPW +: OPW] = mkop($urandom_range(0,3) != 0, $urandom_range(0,1),
                                       $urandom_range(0,3), $urandom_range(0,7), $urandom_range(0,255));
            step(p, $urandom_range(0,1), $urandom_range(0,7), $urandom_range(0,7),
                 $urandom_range(0,7), $urandom_range(0,1), "R3 R5 R7 random");
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule